// File: doc/BRIEF.md
# Misaligned Load/Store Splitter

This block sits between a core's load/store unit and a word-wide data-memory port that takes aligned addresses only. It accepts one byte, halfword or word access at a time. It then issues one or two word-aligned bus transactions. Each transaction carries byte enables and write data shifted into the lanes that match the original byte address.

When an access crosses a word boundary, the lower word goes out first and the upper word second. When an access is not naturally aligned, its transactions are tagged as the first or second half. For loads, the returned lanes from both words are merged into a right-aligned result and then sign- or zero-extended. An error response on the first half is held and shown with the second-half transaction. The completion carries the OR of both halves' errors.

The controller is a five-state machine:
- `ST_IDLE` accepts a request and moves to `ST_LO_REQ`.
- `ST_LO_REQ` holds the lower request until grant, then moves to `ST_LO_WAIT`.
- `ST_LO_WAIT` waits for the response. From there it goes to `ST_HI_REQ` when the access crosses a word boundary, and back to `ST_IDLE` otherwise.
- `ST_HI_REQ` holds the upper request until grant, then moves to `ST_HI_WAIT`.
- `ST_HI_WAIT` returns to `ST_IDLE` on the second response.

Top module: `mis_lsu_splitter`

## Requirements
- R1: Every bus address has its two low bits zero. Write data and byte enables sit in the lanes of the original address. For example, a byte store of 0xFF to 0x12 goes out at 0x10 with data 0x00FF0000 and byte enable 4'b0100. Size encoding: 0 = byte, 1 = halfword, 2 = word (3 acts as word).
- R2: A word access at offset 3 issues two transactions. The first is at the lower word with byte enable 4'b1000 and `bus_first_o`=1. The second is at the next word with byte enable 4'b0111 and `bus_second_o`=1. Store data is split across the two words to match.
- R3: A halfword access at offset 1 stays in one word. It issues a single transaction with byte enable 4'b0110 and `bus_first_o`=1, and no second half follows.
- R4: A naturally aligned access issues exactly one transaction with both tags low.
- R5: The second transaction is not requested before the first response arrives, so at most one transaction is outstanding.
- R6: Load data from the one or two words is shifted down to bit 0 and merged. The result is sign-extended when `core_signed_i`=1 and zero-extended otherwise.
- R7: An error on the first half shows as `bus_prior_err_o`=1 with the second-half transaction. The flag is never set on a first-half transaction.
- R8: `core_done_o` pulses for one cycle only after the last response of the access. `core_err_o` is the OR of the errors of all its halves.
- R9: Every transaction carries the machine-mode flag captured with the access.
- R10: A bus request and its address and byte enables stay unchanged until granted.
- R11: `core_gnt_o` is high only while idle. A core request made while busy is ignored and issues no transaction.
- R12: After reset, `core_gnt_o`=1, `bus_req_o`=0 and `core_done_o`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| core_req_i | input | 1 | Core access request |
| core_gnt_o | output | 1 | Request accepted (high when idle) |
| core_we_i | input | 1 | 1 = store, 0 = load |
| core_size_i | input | 2 | 0 byte, 1 halfword, 2 word |
| core_signed_i | input | 1 | Sign-extend load result |
| core_addr_i | input | 32 | Byte address |
| core_wdata_i | input | 32 | Right-aligned store data |
| core_mmode_i | input | 1 | Access made in machine mode |
| core_done_o | output | 1 | Access complete (one-cycle pulse) |
| core_rdata_o | output | 32 | Merged, extended load result |
| core_err_o | output | 1 | Error on any half |
| bus_req_o | output | 1 | Bus transaction request |
| bus_gnt_i | input | 1 | Bus grant |
| bus_addr_o | output | 32 | Word-aligned address |
| bus_we_o | output | 1 | Transaction is a store |
| bus_be_o | output | 4 | Byte enables |
| bus_wdata_o | output | 32 | Lane-placed write data |
| bus_first_o | output | 1 | Lower half of a misaligned access |
| bus_second_o | output | 1 | Upper half of a misaligned access |
| bus_prior_err_o | output | 1 | First half returned an error |
| bus_mmode_o | output | 1 | Machine-mode flag |
| bus_rvalid_i | input | 1 | Response valid |
| bus_rdata_i | input | 32 | Response read data |
| bus_err_i | input | 1 | Response error |

## Verification
The assertions assume the bus returns exactly one `bus_rvalid_i` for each granted request, in order, and never a response without a request in flight. The bench's bus model follows this rule. It grants only a pending request, answers exactly one cycle after the grant, and can stall grants for a set number of cycles.

The core-side stimulus never changes a request's fields in the accepting cycle. It keeps every address within the model's small word memory so that expected load data can be built byte by byte from that memory.

// File: rtl/mls_pkg.sv
package mls_pkg;
    localparam logic [1:0] SZ_BYTE = 2'd0;
    localparam logic [1:0] SZ_HALF = 2'd1;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LO_REQ,
        ST_LO_WAIT,
        ST_HI_REQ,
        ST_HI_WAIT
    } state_e;
endpackage

// File: rtl/mls_lane_plan.sv
module mls_lane_plan
    import mls_pkg::*;
#(
    parameter int DATA_W = 32,
    localparam int BYTES = DATA_W / 8,
    localparam int OFF_W = $clog2(BYTES)
) (
    input  logic [OFF_W-1:0]  off_i,
    input  logic [1:0]        size_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [BYTES-1:0]  be_lo_o,
    output logic [BYTES-1:0]  be_hi_o,
    output logic [DATA_W-1:0] wd_lo_o,
    output logic [DATA_W-1:0] wd_hi_o,
    output logic              split_o,
    output logic              misal_o
);
    logic [OFF_W:0]          nbytes;
    logic [2*BYTES-1:0]      be_base;
    logic [DATA_W-1:0]       wd_m;

    always_comb begin
        if (size_i == SZ_BYTE)      nbytes = (OFF_W+1)'(1);
        else if (size_i == SZ_HALF) nbytes = (OFF_W+1)'(2);
        else                        nbytes = (OFF_W+1)'(BYTES);
        be_base = ((2*BYTES)'(1) << nbytes) - (2*BYTES)'(1);
    end

    for (genvar i = 0; i < BYTES; i++) begin : g_wmask
        assign wd_m[8*i +: 8] = be_base[i] ? wdata_i[8*i +: 8] : 8'h00;
    end

    assign {be_hi_o, be_lo_o} = be_base << off_i;
    assign {wd_hi_o, wd_lo_o} = {{DATA_W{1'b0}}, wd_m} << {off_i, 3'b000};
    assign split_o = |be_hi_o;
    assign misal_o = (({1'b0, off_i} & (nbytes - (OFF_W+1)'(1))) != '0);
endmodule

// File: rtl/mls_load_merge.sv
module mls_load_merge
    import mls_pkg::*;
#(
    parameter int DATA_W = 32,
    localparam int OFF_W = $clog2(DATA_W / 8)
) (
    input  logic [DATA_W-1:0] lo_i,
    input  logic [DATA_W-1:0] hi_i,
    input  logic [OFF_W-1:0]  off_i,
    input  logic [1:0]        size_i,
    input  logic              signed_i,
    output logic [DATA_W-1:0] res_o
);
    logic [DATA_W-1:0] s;

    always_comb begin
        s = DATA_W'({hi_i, lo_i} >> {off_i, 3'b000});
        if (size_i == SZ_BYTE)
            res_o = {{(DATA_W-8){signed_i & s[7]}}, s[7:0]};
        else if (size_i == SZ_HALF)
            res_o = {{(DATA_W-16){signed_i & s[15]}}, s[15:0]};
        else
            res_o = s;
    end
endmodule

// File: rtl/mis_lsu_splitter.sv
module mis_lsu_splitter
    import mls_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    localparam int BYTES  = DATA_W / 8,
    localparam int OFF_W  = $clog2(BYTES),
    localparam int WORD_W = ADDR_W - OFF_W
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              core_req_i,
    output logic              core_gnt_o,
    input  logic              core_we_i,
    input  logic [1:0]        core_size_i,
    input  logic              core_signed_i,
    input  logic [ADDR_W-1:0] core_addr_i,
    input  logic [DATA_W-1:0] core_wdata_i,
    input  logic              core_mmode_i,
    output logic              core_done_o,
    output logic [DATA_W-1:0] core_rdata_o,
    output logic              core_err_o,
    output logic              bus_req_o,
    input  logic              bus_gnt_i,
    output logic [ADDR_W-1:0] bus_addr_o,
    output logic              bus_we_o,
    output logic [BYTES-1:0]  bus_be_o,
    output logic [DATA_W-1:0] bus_wdata_o,
    output logic              bus_first_o,
    output logic              bus_second_o,
    output logic              bus_prior_err_o,
    output logic              bus_mmode_o,
    input  logic              bus_rvalid_i,
    input  logic [DATA_W-1:0] bus_rdata_i,
    input  logic              bus_err_i
);
    state_e             st_q, st_d;
    logic [WORD_W-1:0]  word_q;
    logic [OFF_W-1:0]   off_q;
    logic [1:0]         size_q;
    logic               we_q, sgn_q, mm_q, err1_q;
    logic [DATA_W-1:0]  wdata_q, lo_q;
    logic               done_q, cerr_q;
    logic [DATA_W-1:0]  rdata_q;

    logic [BYTES-1:0]   be_lo, be_hi;
    logic [DATA_W-1:0]  wd_lo, wd_hi, mrg_lo, mrg_hi, merged;
    logic               split, misal, hi_phase, accept, last_resp;

    mls_lane_plan #(.DATA_W(DATA_W)) u_plan (
        .off_i   (off_q),
        .size_i  (size_q),
        .wdata_i (wdata_q),
        .be_lo_o (be_lo),
        .be_hi_o (be_hi),
        .wd_lo_o (wd_lo),
        .wd_hi_o (wd_hi),
        .split_o (split),
        .misal_o (misal)
    );

    assign mrg_lo = (st_q == ST_HI_WAIT) ? lo_q : bus_rdata_i;
    assign mrg_hi = (st_q == ST_HI_WAIT) ? bus_rdata_i : '0;

    mls_load_merge #(.DATA_W(DATA_W)) u_merge (
        .lo_i     (mrg_lo),
        .hi_i     (mrg_hi),
        .off_i    (off_q),
        .size_i   (size_q),
        .signed_i (sgn_q),
        .res_o    (merged)
    );

    assign accept    = (st_q == ST_IDLE) && core_req_i;
    assign last_resp = bus_rvalid_i &&
                       (((st_q == ST_LO_WAIT) && !split) || (st_q == ST_HI_WAIT));

    // next-state selection
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE:    if (core_req_i)   st_d = ST_LO_REQ;
            ST_LO_REQ:  if (bus_gnt_i)    st_d = ST_LO_WAIT;
            ST_LO_WAIT: if (bus_rvalid_i) st_d = split ? ST_HI_REQ : ST_IDLE;
            ST_HI_REQ:  if (bus_gnt_i)    st_d = ST_HI_WAIT;
            ST_HI_WAIT: if (bus_rvalid_i) st_d = ST_IDLE;
            default:                      st_d = ST_IDLE;
        endcase
    end

    // state register and captured access
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q    <= ST_IDLE;
            word_q  <= '0;
            off_q   <= '0;
            size_q  <= '0;
            we_q    <= 1'b0;
            sgn_q   <= 1'b0;
            mm_q    <= 1'b0;
            wdata_q <= '0;
            lo_q    <= '0;
            err1_q  <= 1'b0;
            done_q  <= 1'b0;
            cerr_q  <= 1'b0;
            rdata_q <= '0;
        end else begin
            st_q   <= st_d;
            done_q <= last_resp;
            if (accept) begin
                word_q  <= core_addr_i[ADDR_W-1:OFF_W];
                off_q   <= core_addr_i[OFF_W-1:0];
                size_q  <= core_size_i;
                we_q    <= core_we_i;
                sgn_q   <= core_signed_i;
                mm_q    <= core_mmode_i;
                wdata_q <= core_wdata_i;
                err1_q  <= 1'b0;
            end
            if ((st_q == ST_LO_WAIT) && bus_rvalid_i) begin
                lo_q   <= bus_rdata_i;
                err1_q <= bus_err_i;
            end
            if (last_resp) begin
                rdata_q <= we_q ? '0 : merged;
                cerr_q  <= bus_err_i | ((st_q == ST_HI_WAIT) && err1_q);
            end
        end
    end

    // outputs
    always_comb begin
        hi_phase        = (st_q == ST_HI_REQ);
        core_gnt_o      = (st_q == ST_IDLE);
        bus_req_o       = (st_q == ST_LO_REQ) || hi_phase;
        bus_addr_o      = {word_q + WORD_W'(hi_phase), {OFF_W{1'b0}}};
        bus_we_o        = we_q;
        bus_be_o        = hi_phase ? be_hi : be_lo;
        bus_wdata_o     = hi_phase ? wd_hi : wd_lo;
        bus_first_o     = (st_q == ST_LO_REQ) && misal;
        bus_second_o    = hi_phase;
        bus_prior_err_o = hi_phase && err1_q;
        bus_mmode_o     = mm_q;
        core_done_o     = done_q;
        core_rdata_o    = rdata_q;
        core_err_o      = cerr_q;
    end
endmodule

// File: rtl/mis_lsu_splitter_chk.sv
module mis_lsu_splitter_chk #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    localparam int BYTES = DATA_W / 8,
    localparam int OFF_W = $clog2(BYTES)
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic              core_gnt_o,
    input logic              core_done_o,
    input logic              bus_req_o,
    input logic              bus_gnt_i,
    input logic [ADDR_W-1:0] bus_addr_o,
    input logic [BYTES-1:0]  bus_be_o,
    input logic              bus_first_o,
    input logic              bus_second_o,
    input logic              bus_prior_err_o,
    input logic              bus_rvalid_i
);
    logic outst_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                     outst_q <= 1'b0;
        else if (bus_req_o && bus_gnt_i) outst_q <= 1'b1;
        else if (bus_rvalid_i)           outst_q <= 1'b0;
    end

    p_word_aligned_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        bus_req_o |-> (bus_addr_o[OFF_W-1:0] == '0));

    p_tags_exclusive_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        bus_req_o |-> !(bus_first_o && bus_second_o));

    p_upper_from_lane0_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (bus_req_o && bus_second_o) |-> bus_be_o[0]);

    p_single_outstanding_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        bus_req_o |-> !outst_q);

    p_prior_err_upper_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        bus_prior_err_o |-> (bus_req_o && bus_second_o));

    p_done_after_resp_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        core_done_o |-> $past(bus_rvalid_i));

    p_hold_until_gnt_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (bus_req_o && !bus_gnt_i) |=>
            (bus_req_o && $stable(bus_addr_o) && $stable(bus_be_o)));

    p_busy_no_gnt_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (bus_req_o || outst_q) |-> !core_gnt_o);
endmodule

bind mis_lsu_splitter mis_lsu_splitter_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk_i           (clk_i),
    .rst_ni          (rst_ni),
    .core_gnt_o      (core_gnt_o),
    .core_done_o     (core_done_o),
    .bus_req_o       (bus_req_o),
    .bus_gnt_i       (bus_gnt_i),
    .bus_addr_o      (bus_addr_o),
    .bus_be_o        (bus_be_o),
    .bus_first_o     (bus_first_o),
    .bus_second_o    (bus_second_o),
    .bus_prior_err_o (bus_prior_err_o),
    .bus_rvalid_i    (bus_rvalid_i)
);

// File: tb/mis_lsu_splitter_test.sv
`timescale 1ns/1ps
module mis_lsu_splitter_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        core_req = 1'b0, core_we = 1'b0, core_signed = 1'b0, core_mmode = 1'b0;
    logic [1:0]  core_size = 2'd0;
    logic [31:0] core_addr = '0, core_wdata = '0;
    logic        core_gnt, core_done, core_err;
    logic [31:0] core_rdata;
    logic        bus_req, bus_we, bus_first, bus_second, bus_perr, bus_mmode;
    logic [31:0] bus_addr, bus_wdata;
    logic [3:0]  bus_be;
    logic        bus_gnt = 1'b0, bus_rvalid = 1'b0, bus_err = 1'b0;
    logic [31:0] bus_rdata = '0;

    int checks = 0, fails = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    mis_lsu_splitter uut (
        .clk_i(clk), .rst_ni(rst_n),
        .core_req_i(core_req), .core_gnt_o(core_gnt), .core_we_i(core_we),
        .core_size_i(core_size), .core_signed_i(core_signed), .core_addr_i(core_addr),
        .core_wdata_i(core_wdata), .core_mmode_i(core_mmode), .core_done_o(core_done),
        .core_rdata_o(core_rdata), .core_err_o(core_err),
        .bus_req_o(bus_req), .bus_gnt_i(bus_gnt), .bus_addr_o(bus_addr), .bus_we_o(bus_we),
        .bus_be_o(bus_be), .bus_wdata_o(bus_wdata), .bus_first_o(bus_first),
        .bus_second_o(bus_second), .bus_prior_err_o(bus_perr), .bus_mmode_o(bus_mmode),
        .bus_rvalid_i(bus_rvalid), .bus_rdata_i(bus_rdata), .bus_err_i(bus_err)
    );

    // bus model state
    logic [31:0] mem [0:15];
    logic [31:0] err_addr = 32'hFFFF_FFFF;
    int          stall_cfg = 0, stall_cnt = 0;
    bit          pend = 0;
    logic [31:0] paddr;
    int          lg_n = 0, resp_n = 0;
    logic [31:0] lg_addr [0:3], lg_wd [0:3];
    logic [3:0]  lg_be [0:3];
    logic        lg_first [0:3], lg_second [0:3], lg_perr [0:3], lg_mm [0:3];

    always @(negedge clk) begin
        bus_gnt = 1'b0; bus_rvalid = 1'b0; bus_err = 1'b0;
        if (rst_n) begin
            if (pend) begin
                bus_rvalid = 1'b1;
                bus_rdata  = mem[paddr[5:2]];
                bus_err    = (paddr == err_addr);
                pend = 0;
                resp_n++;
            end else if (bus_req) begin
                if (stall_cnt < stall_cfg) stall_cnt++;
                else begin
                    stall_cnt = 0;
                    bus_gnt = 1'b1;
                    pend = 1;
                    paddr = bus_addr;
                    if (lg_n < 4) begin
                        lg_addr[lg_n] = bus_addr; lg_wd[lg_n] = bus_wdata; lg_be[lg_n] = bus_be;
                        lg_first[lg_n] = bus_first; lg_second[lg_n] = bus_second;
                        lg_perr[lg_n] = bus_perr; lg_mm[lg_n] = bus_mmode;
                    end
                    lg_n++;
                    if (bus_we)
                        for (int b = 0; b < 4; b++)
                            if (bus_be[b]) mem[bus_addr[5:2]][8*b +: 8] = bus_wdata[8*b +: 8];
                end
            end
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] mbyte(input logic [31:0] a);
        return mem[a[5:2]][8*a[1:0] +: 8];
    endfunction

    function automatic logic [31:0] exp_load(input logic [31:0] a, input logic [1:0] sz, input logic sg);
        logic [31:0] v;
        v = {mbyte(a + 3), mbyte(a + 2), mbyte(a + 1), mbyte(a)};
        if (sz == 2'd0) return {{24{sg & v[7]}}, v[7:0]};
        if (sz == 2'd1) return {{16{sg & v[15]}}, v[15:0]};
        return v;
    endfunction

    logic [31:0] res_data;
    logic        res_err;
    int          resp_at_done;

    task automatic run_access(input logic we, input logic [1:0] sz, input logic sg,
                              input logic [31:0] a, input logic [31:0] wd, input logic mm);
        int t;
        lg_n = 0; resp_n = 0;
        @(negedge clk);
        core_req = 1'b1; core_we = we; core_size = sz; core_signed = sg;
        core_addr = a; core_wdata = wd; core_mmode = mm;
        @(negedge clk);
        core_req = 1'b0;
        t = 0;
        while (!core_done && t < 100) begin @(negedge clk); t++; end
        res_data = core_rdata; res_err = core_err; resp_at_done = resp_n;
    endtask

    task automatic t_reset;
        check("R12 core_gnt", 32'(core_gnt), 32'd1);
        check("R12 bus_req", 32'(bus_req), 32'd0);
        check("R12 core_done", 32'(core_done), 32'd0);
    endtask

    task automatic t_byte_store;
        run_access(1'b1, 2'd0, 1'b0, 32'h12, 32'h0000_00FF, 1'b0);
        check("R4 txn count", 32'(lg_n), 32'd1);
        check("R1 addr", lg_addr[0], 32'h10);
        check("R1 wdata", lg_wd[0], 32'h00FF_0000);
        check("R1 be", 32'(lg_be[0]), 32'b0100);
        check("R4 tags", {30'd0, lg_first[0], lg_second[0]}, 32'd0);
        check("R1 mem lane", 32'(mbyte(32'h12)), 32'hFF);
    endtask

    task automatic t_half_single;
        logic [31:0] e;
        e = exp_load(32'h1, 2'd1, 1'b1);
        run_access(1'b0, 2'd1, 1'b1, 32'h1, 32'h0, 1'b1);
        check("R3 txn count", 32'(lg_n), 32'd1);
        check("R3 addr", lg_addr[0], 32'h0);
        check("R3 be", 32'(lg_be[0]), 32'b0110);
        check("R3 tags", {30'd0, lg_first[0], lg_second[0]}, 32'b10);
        check("R6 half signed", res_data, e);
        check("R6 half signed value", res_data, 32'hFFFF_F123);
    endtask

    task automatic t_word_split;
        run_access(1'b1, 2'd2, 1'b0, 32'h3, 32'hAABB_CCDD, 1'b1);
        check("R2 txn count", 32'(lg_n), 32'd2);
        check("R2 lo addr", lg_addr[0], 32'h0);
        check("R2 lo be", 32'(lg_be[0]), 32'b1000);
        check("R2 lo wdata", lg_wd[0], 32'hDD00_0000);
        check("R2 lo tags", {30'd0, lg_first[0], lg_second[0]}, 32'b10);
        check("R2 hi addr", lg_addr[1], 32'h4);
        check("R2 hi be", 32'(lg_be[1]), 32'b0111);
        check("R2 hi wdata", lg_wd[1], 32'h00AA_BBCC);
        check("R2 hi tags", {30'd0, lg_first[1], lg_second[1]}, 32'b01);
        check("R9 mmode both", {30'd0, lg_mm[0], lg_mm[1]}, 32'b11);
        run_access(1'b0, 2'd2, 1'b0, 32'h3, 32'h0, 1'b0);
        check("R6 word merge", res_data, 32'hAABB_CCDD);
        check("R9 mmode low", {30'd0, lg_mm[0], lg_mm[1]}, 32'b00);
    endtask

    task automatic t_merges;
        logic [31:0] e;
        e = exp_load(32'h7, 2'd1, 1'b0);
        run_access(1'b0, 2'd1, 1'b0, 32'h7, 32'h0, 1'b0);
        check("R6 half split unsigned", res_data, e);
        check("R2 half split be", {24'd0, lg_be[0], lg_be[1]}, 32'h81);
        e = exp_load(32'h7, 2'd1, 1'b1);
        run_access(1'b0, 2'd1, 1'b1, 32'h7, 32'h0, 1'b0);
        check("R6 half split signed", res_data, e);
        e = exp_load(32'h9, 2'd0, 1'b1);
        run_access(1'b0, 2'd0, 1'b1, 32'h9, 32'h0, 1'b0);
        check("R6 byte signed", res_data, e);
        e = exp_load(32'h9, 2'd0, 1'b0);
        run_access(1'b0, 2'd0, 1'b0, 32'h9, 32'h0, 1'b0);
        check("R6 byte unsigned", res_data, e);
        check("R4 aligned byte tags", {30'd0, lg_first[0], lg_second[0]}, 32'd0);
    endtask

    task automatic t_first_err;
        err_addr = 32'h20;
        run_access(1'b0, 2'd2, 1'b0, 32'h22, 32'h0, 1'b0);
        check("R5 txn count", 32'(lg_n), 32'd2);
        check("R7 lo prior flag", 32'(lg_perr[0]), 32'd0);
        check("R7 hi prior flag", 32'(lg_perr[1]), 32'd1);
        check("R8 err from lower", 32'(res_err), 32'd1);
        check("R8 done after last resp", 32'(resp_at_done), 32'd2);
        err_addr = 32'hFFFF_FFFF;
    endtask

    task automatic t_second_err;
        err_addr = 32'h2C;
        run_access(1'b0, 2'd2, 1'b0, 32'h2A, 32'h0, 1'b0);
        check("R7 hi prior clean", 32'(lg_perr[1]), 32'd0);
        check("R8 err from upper", 32'(res_err), 32'd1);
        err_addr = 32'hFFFF_FFFF;
        run_access(1'b0, 2'd2, 1'b0, 32'h2A, 32'h0, 1'b0);
        check("R8 no err", 32'(res_err), 32'd0);
    endtask

    task automatic t_busy_ignored;
        int t;
        stall_cfg = 3; lg_n = 0;
        @(negedge clk);
        core_req = 1'b1; core_we = 1'b0; core_size = 2'd2; core_signed = 1'b0;
        core_addr = 32'h14; core_mmode = 1'b0;
        @(negedge clk);
        core_addr = 32'h30;
        for (int k = 0; k < 2; k++) begin
            check("R11 no gnt busy", 32'(core_gnt), 32'd0);
            check("R10 held addr", bus_addr, 32'h14);
            @(negedge clk);
        end
        core_req = 1'b0;
        t = 0;
        while (!core_done && t < 100) begin @(negedge clk); t++; end
        repeat (4) @(negedge clk);
        check("R11 busy request dropped", 32'(lg_n), 32'd1);
        check("R10 granted addr", lg_addr[0], 32'h14);
        stall_cfg = 0;
    endtask

    initial begin
        for (int i = 0; i < 16; i++) mem[i] = 32'h1111_1111 * (i + 1);
        mem[0] = 32'h8CF1_2345;
        mem[2] = 32'h0000_9C00;
        repeat (3) @(negedge clk);
        t_reset;
        rst_n = 1'b1;
        @(negedge clk);
        t_reset;
        t_byte_store;
        t_half_single;
        t_word_split;
        t_merges;
        t_first_err;
        t_second_err;
        t_busy_ignored;
        if (!finished) begin
            finished = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        #(20 * 200000);
        if (!finished) begin
            finished = 1;
            checks++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule